// File: doc/BRIEF.md
# Level/Edge Interrupt Pending Tracker

This block holds the per-line bookkeeping for a bank of shared peripheral interrupt lines. For every line it stores four bits: the trigger mode (level or edge), a pending bit, an active bit, and a flag that records whether software made the line pending. Hardware assert and deassert events, software set-pending and clear-pending mask writes, trigger-mode configuration writes, and acknowledge or deactivate commands all update that state. The block presents the pending and active vectors, an any-pending summary and an error pulse. All outputs are registered, so every effect shows up in the cycle after the command.

A level-sensitive line normally follows its wire: it becomes pending when it asserts and stops being pending when it deasserts. A level-sensitive line that software made pending is different. It behaves like an edge-triggered line when it is cleared or acknowledged, until the next hardware assertion hands it back to its wire. Interrupt ID `BASE_ID + k` addresses internal line `k`. IDs outside the implemented range are rejected.

Top module: `irq_pend_tracker`

## Requirements
- R1: After reset every line is level-sensitive, not pending and not active, its software flag is clear, and `err_o` and `any_pending_o` are low.
- R2: A hardware assert pulse on line k sets pending[k] and clears the software flag of line k in the next cycle.
- R3: A software set-pending write with word index w and mask m sets pending and the software flag for each interrupt ID w*32+i where m[i]=1. ID `BASE_ID+k` maps to line k. Mask bits that fall on IDs with no line have no effect.
- R4: A hardware deassert pulse clears pending only on a line that is level-sensitive with its software flag clear. Edge-mode lines and flagged lines stay pending.
- R5: A line is edge-like when its mode is edge or its software flag is set. A software clear-pending write, using the same word and mask mapping as R3, clears pending only on selected edge-like lines. Other selected lines keep their pending bit.
- R6: When a set (hardware assert or software set-pending) and any clear (deassert, clear-pending, acknowledge) hit the same line in the same cycle, the line ends up pending. If a hardware assert and a software set hit the same line together, the software flag ends up set.
- R7: An acknowledge with an in-range ID always sets that line's active bit. It clears the line's pending bit only if the line is edge-like.
- R8: A deactivate with an in-range ID clears the active bit. If an acknowledge and a deactivate name the same ID in one cycle, the line ends up active.
- R9: Valid IDs run from `BASE_ID` to `BASE_ID+N_LINES-1`. An acknowledge or deactivate with any other ID drives `err_o` high for exactly the following cycle and changes no pending or active bit.
- R10: A configuration write with word index w, select mask m and value vector v sets the mode of each line whose ID is w*32+i with m[i]=1: v[i]=1 selects edge and v[i]=0 selects level. The new mode governs commands from the next cycle on.
- R11: `any_pending_o` is high exactly when at least one bit of `pending_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hw_assert_i | input | N_LINES | Per-line hardware assert event pulses |
| hw_deassert_i | input | N_LINES | Per-line hardware deassert event pulses |
| set_valid_i | input | 1 | Software set-pending write strobe |
| set_word_i | input | WIDX_W | Set-pending word index |
| set_mask_i | input | 32 | Set-pending line mask |
| clr_valid_i | input | 1 | Software clear-pending write strobe |
| clr_word_i | input | WIDX_W | Clear-pending word index |
| clr_mask_i | input | 32 | Clear-pending line mask |
| cfg_valid_i | input | 1 | Trigger-mode write strobe |
| cfg_word_i | input | WIDX_W | Trigger-mode word index |
| cfg_mask_i | input | 32 | Lines whose mode is written |
| cfg_edge_i | input | 32 | New modes, 1 = edge, 0 = level |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | ID_W | Acknowledged interrupt ID |
| deact_valid_i | input | 1 | Deactivate strobe |
| deact_id_i | input | ID_W | Deactivated interrupt ID |
| pending_o | output | N_LINES | Pending vector |
| active_o | output | N_LINES | Active vector |
| any_pending_o | output | 1 | OR of all pending bits |
| err_o | output | 1 | One-cycle pulse for a rejected ID |

## Verification
The assertions check the following on every cycle:
- an asserted line is pending next cycle;
- an in-range acknowledge leaves the line active;
- a deactivate that no acknowledge overrides leaves the line inactive;
- a rejected ID pulses the error, and a valid one does not;
- cycles whose only commands are rejected ones leave pending and active unchanged;
- the any-pending summary matches the pending vector.

The interplay of trigger mode and software flag cannot be captured without a model of the whole line state. This covers a deassert or clear that is ignored on a level line but honoured on an edge or flagged line, and an acknowledge that leaves a level line pending. The bench's sweeps and its long mixed-traffic run show this part against an independent model.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    // Per-line state held by the tracker.
    typedef struct packed {
        logic edge_mode;   // 1 = edge-triggered, 0 = level-sensitive
        logic pend;        // line is pending
        logic act;         // line is active
        logic swf;         // pending was last set by software
    } line_st_t;

    localparam line_st_t LINE_RESET = '{edge_mode: 1'b0, pend: 1'b0, act: 1'b0, swf: 1'b0};

endpackage

// File: rtl/irqt_word_sel.sv
// Maps a (word index, 32-bit mask) write onto the per-line select vector.
// Line k carries interrupt ID BASE_ID+k, i.e. word (BASE_ID+k)/32, bit (BASE_ID+k)%32.
module irqt_word_sel #(
    parameter int unsigned N_LINES = 64,
    parameter int unsigned BASE_ID = 32,
    parameter int unsigned WIDX_W  = 2
) (
    input  logic               valid_i,
    input  logic [WIDX_W-1:0]  word_i,
    input  logic [31:0]        mask_i,
    output logic [N_LINES-1:0] sel_o
);
    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        localparam int unsigned LID  = BASE_ID + k;
        localparam int unsigned LWRD = LID / 32;
        localparam int unsigned LBIT = LID % 32;
        assign sel_o[k] = valid_i && (word_i == WIDX_W'(LWRD)) && mask_i[LBIT];
    end
endmodule

// File: rtl/irqt_id_chk.sv
// Range check and one-hot decode of an interrupt ID (R9).
module irqt_id_chk #(
    parameter int unsigned N_LINES = 64,
    parameter int unsigned BASE_ID = 32,
    parameter int unsigned ID_W    = 10
) (
    input  logic               valid_i,
    input  logic [ID_W-1:0]    id_i,
    output logic [N_LINES-1:0] hit_o,
    output logic               bad_o
);
    localparam logic [ID_W:0] ID_LO = (ID_W+1)'(BASE_ID);
    localparam logic [ID_W:0] ID_HI = (ID_W+1)'(BASE_ID + N_LINES);

    logic in_range;
    assign in_range = ({1'b0, id_i} >= ID_LO) && ({1'b0, id_i} < ID_HI);
    assign bad_o    = valid_i && !in_range;

    for (genvar k = 0; k < N_LINES; k++) begin : g_hit
        assign hit_o[k] = valid_i && (id_i == ID_W'(BASE_ID + k));
    end
endmodule

// File: rtl/irqt_line.sv
// Next-state logic of a single interrupt line.
module irqt_line
    import irqt_pkg::*;
(
    input  line_st_t st_q,
    input  logic     hw_set_i,
    input  logic     hw_clr_i,
    input  logic     sw_set_i,
    input  logic     sw_clr_i,
    input  logic     ack_i,
    input  logic     deact_i,
    input  logic     cfg_sel_i,
    input  logic     cfg_val_i,
    output line_st_t st_d
);
    logic edge_like;

    always_comb begin
        edge_like = st_q.edge_mode | st_q.swf;
        st_d      = st_q;
        // R10: mode write, effective from next cycle
        if (cfg_sel_i) st_d.edge_mode = cfg_val_i;
        // R4: deassert only affects plain level lines
        if (hw_clr_i && !edge_like) st_d.pend = 1'b0;
        // R5: software clear only affects edge-like lines
        if (sw_clr_i && edge_like) st_d.pend = 1'b0;
        // R7: acknowledge clears pending only when edge-like
        if (ack_i && edge_like) st_d.pend = 1'b0;
        // R2 / R6: hardware set beats clears
        if (hw_set_i) begin
            st_d.pend = 1'b1;
            st_d.swf  = 1'b0;
        end
        // R3 / R6: software set beats everything
        if (sw_set_i) begin
            st_d.pend = 1'b1;
            st_d.swf  = 1'b1;
        end
        // R8 / R7: acknowledge wins over deactivate
        if (deact_i) st_d.act = 1'b0;
        if (ack_i)   st_d.act = 1'b1;
    end
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
    import irqt_pkg::*;
#(
    parameter int unsigned N_LINES = 64,
    parameter int unsigned BASE_ID = 32,
    parameter int unsigned ID_W    = 10,
    localparam int unsigned NWORDS = (BASE_ID + N_LINES + 31) / 32,
    localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_LINES-1:0] hw_assert_i,
    input  logic [N_LINES-1:0] hw_deassert_i,
    input  logic               set_valid_i,
    input  logic [WIDX_W-1:0]  set_word_i,
    input  logic [31:0]        set_mask_i,
    input  logic               clr_valid_i,
    input  logic [WIDX_W-1:0]  clr_word_i,
    input  logic [31:0]        clr_mask_i,
    input  logic               cfg_valid_i,
    input  logic [WIDX_W-1:0]  cfg_word_i,
    input  logic [31:0]        cfg_mask_i,
    input  logic [31:0]        cfg_edge_i,
    input  logic               ack_valid_i,
    input  logic [ID_W-1:0]    ack_id_i,
    input  logic               deact_valid_i,
    input  logic [ID_W-1:0]    deact_id_i,
    output logic [N_LINES-1:0] pending_o,
    output logic [N_LINES-1:0] active_o,
    output logic               any_pending_o,
    output logic               err_o
);
    typedef struct packed {
        line_st_t [N_LINES-1:0] lines;
        logic                   err;
    } state_t;

    state_t st_q, st_d;

    logic [N_LINES-1:0] set_sel, clr_sel, cfg_sel, cfg_val;
    logic [N_LINES-1:0] ack_hit, deact_hit;
    logic               ack_bad, deact_bad;
    line_st_t [N_LINES-1:0] line_nxt;

    // Word/mask decoders (R3, R5, R10)
    irqt_word_sel #(.N_LINES(N_LINES), .BASE_ID(BASE_ID), .WIDX_W(WIDX_W)) u_set_sel (
        .valid_i(set_valid_i), .word_i(set_word_i), .mask_i(set_mask_i), .sel_o(set_sel));
    irqt_word_sel #(.N_LINES(N_LINES), .BASE_ID(BASE_ID), .WIDX_W(WIDX_W)) u_clr_sel (
        .valid_i(clr_valid_i), .word_i(clr_word_i), .mask_i(clr_mask_i), .sel_o(clr_sel));
    irqt_word_sel #(.N_LINES(N_LINES), .BASE_ID(BASE_ID), .WIDX_W(WIDX_W)) u_cfg_sel (
        .valid_i(cfg_valid_i), .word_i(cfg_word_i), .mask_i(cfg_mask_i), .sel_o(cfg_sel));
    // Same mapping applied to the value vector yields each line's new mode bit
    irqt_word_sel #(.N_LINES(N_LINES), .BASE_ID(BASE_ID), .WIDX_W(WIDX_W)) u_cfg_val (
        .valid_i(cfg_valid_i), .word_i(cfg_word_i), .mask_i(cfg_edge_i), .sel_o(cfg_val));

    // ID decoders (R7, R8, R9)
    irqt_id_chk #(.N_LINES(N_LINES), .BASE_ID(BASE_ID), .ID_W(ID_W)) u_ack_chk (
        .valid_i(ack_valid_i), .id_i(ack_id_i), .hit_o(ack_hit), .bad_o(ack_bad));
    irqt_id_chk #(.N_LINES(N_LINES), .BASE_ID(BASE_ID), .ID_W(ID_W)) u_deact_chk (
        .valid_i(deact_valid_i), .id_i(deact_id_i), .hit_o(deact_hit), .bad_o(deact_bad));

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        irqt_line u_line (
            .st_q     (st_q.lines[k]),
            .hw_set_i (hw_assert_i[k]),
            .hw_clr_i (hw_deassert_i[k]),
            .sw_set_i (set_sel[k]),
            .sw_clr_i (clr_sel[k]),
            .ack_i    (ack_hit[k]),
            .deact_i  (deact_hit[k]),
            .cfg_sel_i(cfg_sel[k]),
            .cfg_val_i(cfg_val[k]),
            .st_d     (line_nxt[k])
        );
        assign pending_o[k] = st_q.lines[k].pend;
        assign active_o[k]  = st_q.lines[k].act;
    end

    always_comb begin
        st_d       = st_q;
        st_d.lines = line_nxt;
        st_d.err   = ack_bad | deact_bad;   // R9
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.lines <= {N_LINES{LINE_RESET}};
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign any_pending_o = |pending_o;   // R11
    assign err_o         = st_q.err;
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker #(
    parameter int unsigned N_LINES = 64,
    parameter int unsigned BASE_ID = 32,
    parameter int unsigned ID_W    = 10,
    parameter int unsigned WIDX_W  = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_LINES-1:0] hw_assert_i,
    input logic [N_LINES-1:0] hw_deassert_i,
    input logic               set_valid_i,
    input logic               clr_valid_i,
    input logic               cfg_valid_i,
    input logic               ack_valid_i,
    input logic [ID_W-1:0]    ack_id_i,
    input logic               deact_valid_i,
    input logic [ID_W-1:0]    deact_id_i,
    input logic [N_LINES-1:0] pending_o,
    input logic [N_LINES-1:0] active_o,
    input logic               any_pending_o,
    input logic               err_o
);
    localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    logic ack_ok, deact_ok, bad_cmd, same_id, quiet;
    logic [IDX_W-1:0] ack_idx, deact_idx;

    always_comb begin
        ack_ok    = ack_valid_i && (int'(ack_id_i) >= int'(BASE_ID))
                    && (int'(ack_id_i) < int'(BASE_ID + N_LINES));
        deact_ok  = deact_valid_i && (int'(deact_id_i) >= int'(BASE_ID))
                    && (int'(deact_id_i) < int'(BASE_ID + N_LINES));
        bad_cmd   = (ack_valid_i && !ack_ok) || (deact_valid_i && !deact_ok);
        same_id   = ack_ok && deact_ok && (ack_id_i == deact_id_i);
        ack_idx   = IDX_W'(int'(ack_id_i) - int'(BASE_ID));
        deact_idx = IDX_W'(int'(deact_id_i) - int'(BASE_ID));
        quiet     = !(|hw_assert_i) && !(|hw_deassert_i) && !set_valid_i
                    && !clr_valid_i && !cfg_valid_i && !ack_ok && !deact_ok;
    end

    // R2
    p_assert_pends_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|hw_assert_i) |=> ((pending_o & $past(hw_assert_i)) == $past(hw_assert_i)));

    // R7
    p_ack_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_ok |=> active_o[$past(ack_idx)]);

    // R8
    p_deact_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (deact_ok && !same_id) |=> !active_o[$past(deact_idx)]);

    // R9
    p_err_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_cmd |=> err_o);
    p_no_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bad_cmd |=> !err_o);
    p_reject_no_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        quiet |=> ($stable(pending_o) && $stable(active_o)));

    // R11
    p_any_pending_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_pending_o == (pending_o != '0));
endmodule

bind irq_pend_tracker irqt_checker #(
    .N_LINES(N_LINES), .BASE_ID(BASE_ID), .ID_W(ID_W), .WIDX_W(WIDX_W)
) u_irqt_checker (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hw_assert_i(hw_assert_i), .hw_deassert_i(hw_deassert_i),
    .set_valid_i(set_valid_i), .clr_valid_i(clr_valid_i), .cfg_valid_i(cfg_valid_i),
    .ack_valid_i(ack_valid_i), .ack_id_i(ack_id_i),
    .deact_valid_i(deact_valid_i), .deact_id_i(deact_id_i),
    .pending_o(pending_o), .active_o(active_o),
    .any_pending_o(any_pending_o), .err_o(err_o)
);

// File: tb/irq_pend_tracker_test.sv
module irq_pend_tracker_test;
    localparam int TN   = 40;
    localparam int TB   = 32;
    localparam int TIDW = 8;
    localparam int TWW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [TN-1:0]   hw_as, hw_de;
    logic            set_v, clr_v, cfg_v, ack_v, dea_v;
    logic [TWW-1:0]  set_w, clr_w, cfg_w;
    logic [31:0]     set_m, clr_m, cfg_m, cfg_e;
    logic [TIDW-1:0] ack_id, dea_id;
    logic [TN-1:0]   pend, act;
    logic            anyp, err;

    irq_pend_tracker #(.N_LINES(TN), .BASE_ID(TB), .ID_W(TIDW)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .hw_assert_i(hw_as), .hw_deassert_i(hw_de),
        .set_valid_i(set_v), .set_word_i(set_w), .set_mask_i(set_m),
        .clr_valid_i(clr_v), .clr_word_i(clr_w), .clr_mask_i(clr_m),
        .cfg_valid_i(cfg_v), .cfg_word_i(cfg_w), .cfg_mask_i(cfg_m), .cfg_edge_i(cfg_e),
        .ack_valid_i(ack_v), .ack_id_i(ack_id),
        .deact_valid_i(dea_v), .deact_id_i(dea_id),
        .pending_o(pend), .active_o(act), .any_pending_o(anyp), .err_o(err)
    );

    // Bench model of line state
    bit m_mode [TN];
    bit m_pend [TN];
    bit m_act  [TN];
    bit m_swf  [TN];
    bit m_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        hw_as = '0; hw_de = '0;
        set_v = 0; clr_v = 0; cfg_v = 0; ack_v = 0; dea_v = 0;
        set_w = '0; clr_w = '0; cfg_w = '0;
        set_m = '0; clr_m = '0; cfg_m = '0; cfg_e = '0;
        ack_id = '0; dea_id = '0;
    endtask

    function automatic bit in_rng(input int id);
        return (id >= TB) && (id < TB + TN);
    endfunction

    // Apply one command cycle to the model following R2..R10
    task automatic model_step();
        bit np[TN], na[TN], nm[TN], nf[TN];
        for (int k = 0; k < TN; k++) begin
            int id = TB + k;
            int w  = id / 32;
            int b  = id % 32;
            bit ss = set_v && (int'(set_w) == w) && set_m[b];
            bit sc = clr_v && (int'(clr_w) == w) && clr_m[b];
            bit cs = cfg_v && (int'(cfg_w) == w) && cfg_m[b];
            bit ak = ack_v && (int'(ack_id) == id);
            bit dk = dea_v && (int'(dea_id) == id);
            bit el = m_mode[k] | m_swf[k];
            np[k] = m_pend[k]; na[k] = m_act[k]; nf[k] = m_swf[k];
            nm[k] = cs ? cfg_e[b] : m_mode[k];
            if (hw_de[k] && !el) np[k] = 0;
            if (sc && el) np[k] = 0;
            if (ak && el) np[k] = 0;
            if (hw_as[k]) begin np[k] = 1; nf[k] = 0; end
            if (ss) begin np[k] = 1; nf[k] = 1; end
            if (dk) na[k] = 0;
            if (ak) na[k] = 1;
        end
        for (int k = 0; k < TN; k++) begin
            m_pend[k] = np[k]; m_act[k] = na[k]; m_mode[k] = nm[k]; m_swf[k] = nf[k];
        end
        m_err = (ack_v && !in_rng(int'(ack_id))) || (dea_v && !in_rng(int'(dea_id)));
    endtask

    task automatic compare(input string tag);
        logic [63:0] ep, ea;
        ep = '0; ea = '0;
        for (int k = 0; k < TN; k++) begin
            ep[k] = m_pend[k];
            ea[k] = m_act[k];
        end
        chk({tag, " pending"}, 64'(pend), ep);
        chk({tag, " active"}, 64'(act), ea);
        chk("R11 any_pending", 64'(anyp), 64'(ep != 0));
        chk("R9 err", 64'(err), 64'(m_err));
    endtask

    // Inputs are set at a negedge; the result is sampled at the following negedge.
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle_inputs();
    endtask

    task automatic reset_dut();
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int k = 0; k < TN; k++) begin
            m_mode[k] = 0; m_pend[k] = 0; m_act[k] = 0; m_swf[k] = 0;
        end
        m_err = 0;
    endtask

    task automatic sw_set(input int w, input logic [31:0] m);
        set_v = 1; set_w = TWW'(w); set_m = m;
    endtask
    task automatic sw_clr(input int w, input logic [31:0] m);
        clr_v = 1; clr_w = TWW'(w); clr_m = m;
    endtask

    initial begin
        reset_dut();
        // R1: reset state
        chk("R1 pending", 64'(pend), 64'd0);
        chk("R1 active", 64'(act), 64'd0);
        chk("R1 any", 64'(anyp), 64'd0);
        chk("R1 err", 64'(err), 64'd0);
        // R1: reset mode is level -> deassert clears
        hw_as = '1; tick("R2");
        hw_de = '1; tick("R1 level-mode");

        // R2 / R4: per-line assert then deassert on level lines
        for (int k = 0; k < TN; k++) begin
            hw_as[k] = 1'b1; tick("R2");
            hw_de[k] = 1'b1; tick("R4");
        end

        // R3: software set over every word with all mask bits (word 0 and 3 have no lines)
        for (int w = 0; w < 4; w++) begin
            sw_set(w, 32'hFFFF_FFFF); tick("R3");
        end
        // R4: flagged lines ignore deassert
        hw_de = '1; tick("R4 flagged");
        // R5: flagged lines honour clear
        for (int w = 0; w < 4; w++) begin
            sw_clr(w, 32'hFFFF_FFFF); tick("R5 flagged");
        end

        // R5: level unflagged lines ignore clear; R2 assert clears flag
        sw_set(1, 32'h0000_00FF); tick("R3");
        hw_as = '1; tick("R2 flag clear");
        sw_clr(1, 32'hFFFF_FFFF); tick("R5 ignored");
        sw_clr(2, 32'hFFFF_FFFF); tick("R5 ignored");
        hw_de = '1; tick("R4");

        // R10: odd IDs edge
        for (int w = 1; w < 3; w++) begin
            cfg_v = 1; cfg_w = TWW'(w); cfg_m = 32'hFFFF_FFFF; cfg_e = 32'hAAAA_AAAA;
            tick("R10");
        end
        hw_as = '1; tick("R2");
        hw_de = '1; tick("R4 edge stays");
        sw_clr(1, 32'h5555_FFFF); tick("R5 edge");
        sw_clr(2, 32'hFFFF_0000); tick("R5 edge");
        hw_de = '1; tick("R4");
        // partial config mask: only bit 1 of word 1 back to level
        cfg_v = 1; cfg_w = 1; cfg_m = 32'h0000_0002; cfg_e = 32'h0; tick("R10 mask");
        hw_as = '1; tick("R2");
        hw_de = '1; tick("R10 mode effect");

        // R6: set and clears on same line and cycle
        sw_set(1, 32'hFFFF_FFFF); sw_clr(1, 32'hFFFF_FFFF); hw_de = '1; tick("R6");
        hw_as = '1; sw_clr(2, 32'hFFFF_FFFF); hw_de = '1; tick("R6");
        hw_as[3] = 1; sw_set(1, 32'h0000_0008); tick("R6 flag");
        hw_de[3] = 1; tick("R6 flag kept");

        // R7 / R9: acknowledge sweep over all IDs 0..90
        for (int id = 0; id <= 90; id++) begin
            ack_v = 1; ack_id = TIDW'(id); tick(in_rng(id) ? "R7" : "R9 ack");
        end
        // R8 / R9: deactivate sweep, with ack+deact collision on some IDs
        for (int id = 0; id <= 90; id++) begin
            dea_v = 1; dea_id = TIDW'(id);
            if (id % 5 == 0) begin ack_v = 1; ack_id = TIDW'(id); end
            tick(in_rng(id) ? "R8" : "R9 deact");
        end
        // R9: max ID
        ack_v = 1; ack_id = '1; dea_v = 1; dea_id = '1; tick("R9 max");

        // Mixed random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            hw_as = TN'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            hw_de = TN'({$urandom, $urandom} & {$urandom, $urandom});
            set_v = ($urandom % 4) == 0; set_w = TWW'($urandom); set_m = $urandom & $urandom;
            clr_v = ($urandom % 3) == 0; clr_w = TWW'($urandom); clr_m = $urandom;
            cfg_v = ($urandom % 8) == 0; cfg_w = TWW'($urandom); cfg_m = $urandom; cfg_e = $urandom;
            ack_v = ($urandom % 2) == 0; ack_id = TIDW'($urandom_range(20, 80));
            dea_v = ($urandom % 3) == 0; dea_id = TIDW'($urandom_range(20, 80));
            tick("R6 mixed");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule